// File: doc/BRIEF.md
# Flash erase-block select registers

This block is a small register slice for an on-chip flash controller. It holds two byte-wide registers on a simple synchronous register bus. One is an access-enable register whose top bit unlocks the flash control registers. The other is an erase-block select register whose low six bits each name one region of the flash array.

The select register accepts at most one region at a time. A write that names several regions clears it instead of storing the value. The register is also forced to zero whenever the external program/erase enable level is low. The stored selection is decoded into the first and last byte address of the chosen region, with a valid flag, for a downstream erase sequencer.

The access bit is exported on `ctl_access_en` so that neighbouring control registers can apply the same gate. Bus offset 0 is the access-enable register and offset 1 is the select register. All other offsets read zero.

Top module: `fbs_regs`

## Requirements
- R1: After a synchronous active-high reset, both registers hold 0x00, `rdata` is 0x00, `ctl_access_en` is 0, `blk_sel` is 0 and `blk_valid` is 0.
- R2: The access-enable register at offset 0 stores write-data bit 7 on every write, whatever the current gate state. It reads back as that bit in position 7 with bits 6..0 as 0, and `ctl_access_en` follows the stored bit.
- R3: While the access bit is 0, writes to offset 1 are dropped and reads of offset 1 return 0x00, while the stored selection is kept.
- R4: With the gate open and the program/erase level high, a write to offset 1 with zero or one of bits 5..0 set replaces the selection, so a write of 0x00 deselects every region.
- R5: Bits 7 and 6 of the select register ignore write data and always read 0.
- R6: A write to offset 1 with two or more of bits 5..0 set leaves the select register at 0x00.
- R7: While `swe` is 0, the select register becomes 0x00 at the next edge and stays there, and writes to it have no effect.
- R8: The region decode is fixed: bit 0 covers 0x0000-0x03FF, bit 1 0x0400-0x07FF, bit 2 0x0800-0x0BFF, bit 3 0x0C00-0x0FFF, bit 4 0x1000-0x1FFF and bit 5 0x2000-0x2FFF. These bounds appear on `blk_start`/`blk_end`, which are 0 when nothing is selected.
- R9: `blk_valid` is 1 exactly when one select bit is set.
- R10: `rdata` carries the addressed register on the edge after a read strobe, and is 0x00 in any cycle that follows no read strobe and for unmapped offsets.
- R11: A register write changes its outputs on the clock edge that samples the write strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| swe | input | 1 | Program/erase enable level from a control register |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W | Registered read data |
| ctl_access_en | output | 1 | Control-register access gate |
| blk_sel | output | NUM_BLK | One-hot selected region |
| blk_start | output | FA_W | First byte of selected region |
| blk_end | output | FA_W | Last byte of selected region |
| blk_valid | output | 1 | Exactly one region selected |

## Verification
Read data is due one clock edge after the read strobe. A scoreboard queues the expected byte when the strobe is driven, and a monitor compares it at the falling edge that follows the sampling edge. Write effects on `blk_sel`, the address bounds and `ctl_access_en` are due at the edge that samples the strobe, so they are checked at the next falling edge. One case also samples just before that edge to confirm the old value still holds. Dropping `swe` clears the selection one edge later, and that is checked on the same falling-edge grid.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int NUM_BLK     = 6;
  localparam int SMALL_CNT   = 4;
  localparam int SMALL_BYTES = 1024;
  localparam int LARGE_BYTES = 4096;
  localparam int FA_W        = 16;

  function automatic int blk_size(int i);
    return (i < SMALL_CNT) ? SMALL_BYTES : LARGE_BYTES;
  endfunction

  function automatic int blk_base(int i);
    if (i < SMALL_CNT) return i * SMALL_BYTES;
    return SMALL_CNT * SMALL_BYTES + (i - SMALL_CNT) * LARGE_BYTES;
  endfunction

  function automatic int blk_last(int i);
    return blk_base(i) + blk_size(i) - 1;
  endfunction
endpackage

// File: rtl/fbs_access_gate.sv
module fbs_access_gate (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (wr_hit) en_q <= wr_bit;
  end

  // R2: the enable bit is writable regardless of its own state
  assert_en_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> en_q == $past(wr_bit));
endmodule

// File: rtl/fbs_select_reg.sv
module fbs_select_reg #(
  parameter int NUM_BLK = 6,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               swe,
  input  logic               wr_hit,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_BLK-1:0] sel_q
);
  logic [NUM_BLK-1:0] field;
  logic               multi;
  logic               unused_rsvd;

  assign field       = wdata[NUM_BLK-1:0];
  assign multi       = ($countones(field) > 1);
  assign unused_rsvd = ^wdata[DATA_W-1:NUM_BLK];

  always_ff @(posedge clk) begin
    if (rst || !swe)  sel_q <= '0;
    else if (wr_hit)  sel_q <= multi ? '0 : field;
  end

  assert_sel_onehot0_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q));
  assert_swe_low_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !swe |=> sel_q == '0);
  assert_multi_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && swe && $countones(wdata[NUM_BLK-1:0]) > 1) |=> sel_q == '0);
  assert_hold_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && swe) |=> $stable(sel_q));
endmodule

// File: rtl/fbs_region_decode.sv
module fbs_region_decode
  import fbs_pkg::*;
#(
  parameter int NB = NUM_BLK,
  parameter int AW = FA_W
) (
  input  logic [NB-1:0] sel,
  output logic [AW-1:0] start_addr,
  output logic [AW-1:0] end_addr,
  output logic          valid
);
  logic [NB-1:0][AW-1:0] st_term;
  logic [NB-1:0][AW-1:0] en_term;

  for (genvar gi = 0; gi < NB; gi++) begin : g_blk
    assign st_term[gi] = sel[gi] ? AW'(blk_base(gi)) : '0;
    assign en_term[gi] = sel[gi] ? AW'(blk_last(gi)) : '0;
  end

  always_comb begin
    start_addr = '0;
    end_addr   = '0;
    for (int i = 0; i < NB; i++) begin
      start_addr = start_addr | st_term[i];
      end_addr   = end_addr   | en_term[i];
    end
    valid = $onehot(sel);
  end
endmodule

// File: rtl/fbs_regs.sv
module fbs_regs
  import fbs_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int EN_POS  = 7,
  parameter int OFS_EN  = 0,
  parameter int OFS_SEL = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               swe,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rdata,
  output logic               ctl_access_en,
  output logic [NUM_BLK-1:0] blk_sel,
  output logic [FA_W-1:0]    blk_start,
  output logic [FA_W-1:0]    blk_end,
  output logic               blk_valid
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SEL);

  logic hit_en, hit_sel, en_q;
  logic [NUM_BLK-1:0] sel_q;

  assign hit_en  = wr_en && (addr == A_EN);
  assign hit_sel = wr_en && (addr == A_SEL) && en_q;

  fbs_access_gate u_gate (
    .clk(clk), .rst(rst), .wr_hit(hit_en), .wr_bit(wdata[EN_POS]), .en_q(en_q)
  );

  fbs_select_reg #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_sel (
    .clk(clk), .rst(rst), .swe(swe), .wr_hit(hit_sel), .wdata(wdata), .sel_q(sel_q)
  );

  fbs_region_decode u_dec (
    .sel(sel_q), .start_addr(blk_start), .end_addr(blk_end), .valid(blk_valid)
  );

  assign ctl_access_en = en_q;
  assign blk_sel       = sel_q;

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (addr == A_EN)             rdata[EN_POS]        <= en_q;
      else if (addr == A_SEL && en_q) rdata[NUM_BLK-1:0] <= sel_q;
    end
  end

  assert_gate_read_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_SEL && !en_q) |=> rdata == '0);
  assert_gate_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SEL && !en_q && swe) |=> $stable(blk_sel));
  assert_idle_read_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == '0);
  assert_span_order_R8: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> blk_end > blk_start);
  assert_valid_flag_R9: assert property (@(posedge clk) disable iff (rst)
    blk_valid == (blk_sel != '0));
endmodule

// File: tb/fbs_regs_test.sv
module fbs_regs_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       swe = 1;
  logic [1:0] addr = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       ctl_access_en, blk_valid;
  logic [5:0] blk_sel;
  logic [15:0] blk_start, blk_end;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic rd_seen = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  localparam logic [15:0] ST [6] = '{16'h0000, 16'h0400, 16'h0800, 16'h0C00, 16'h1000, 16'h2000};
  localparam logic [15:0] EN [6] = '{16'h03FF, 16'h07FF, 16'h0BFF, 16'h0FFF, 16'h1FFF, 16'h2FFF};

  always #10 clk = ~clk;

  fbs_regs uut (
    .clk(clk), .rst(rst), .swe(swe), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .ctl_access_en(ctl_access_en), .blk_sel(blk_sel),
    .blk_start(blk_start), .blk_end(blk_end), .blk_valid(blk_valid)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read data due one edge after the strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && !rst) begin
      if (exp_q.size() == 0) chk("R10 unexpected read", 32'(rdata), 32'hFFFF_FFFF);
      else chk(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] e, string tag);
    @(negedge clk); addr = a; rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic chk_dec(logic [5:0] s, logic [15:0] st, logic [15:0] en, logic v, string tag);
    chk({tag, " sel"},   32'(blk_sel),   32'(s));
    chk({tag, " start"}, 32'(blk_start), 32'(st));
    chk({tag, " end"},   32'(blk_end),   32'(en));
    chk({tag, " valid"}, 32'(blk_valid), 32'(v));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 rdata", 32'(rdata), 0);
    chk("R1 access", 32'(ctl_access_en), 0);
    chk_dec(0, 0, 0, 0, "R1");
    rd(0, 8'h00, "R1 enable reg");

    // gate closed: select write dropped, read blocked
    wr(1, 8'h01);
    chk_dec(0, 0, 0, 0, "R3 dropped write");
    rd(1, 8'h00, "R3 blocked read");

    wr(0, 8'hFF);
    chk("R2 access out", 32'(ctl_access_en), 1);
    rd(0, 8'h80, "R2 readback");
    rd(2, 8'h00, "R10 unmapped 2");
    rd(3, 8'h00, "R10 unmapped 3");
    @(negedge clk);
    chk("R10 idle rdata", 32'(rdata), 0);

    // each single region in turn (R4, R8, R9)
    for (int i = 0; i < 6; i++) begin
      wr(1, 8'(1 << i));
      chk_dec(6'(1 << i), ST[i], EN[i], 1, "R8 region");
      rd(1, 8'(1 << i), "R4 readback");
    end

    wr(1, 8'hC4);
    chk_dec(6'h04, 16'h0800, 16'h0BFF, 1, "R5 reserved ignored");
    rd(1, 8'h04, "R5 reserved read 0");

    wr(1, 8'h03);
    chk_dec(0, 0, 0, 0, "R6 two bits");
    wr(1, 8'h10);
    wr(1, 8'h21);
    chk_dec(0, 0, 0, 0, "R6 two bits clear prior");
    wr(1, 8'h3F);
    rd(1, 8'h00, "R6 all bits");
    wr(1, 8'h80);
    chk_dec(0, 0, 0, 0, "R4 reserved-only write deselects");

    // R11: old value until the sampling edge
    wr(1, 8'h01);
    @(negedge clk); addr = 1; wdata = 8'h02; wr_en = 1;
    #5 chk("R11 before edge", 32'(blk_sel), 32'h01);
    @(negedge clk); wr_en = 0;
    chk("R11 after edge", 32'(blk_sel), 32'h02);
    wr(1, 8'h00);
    chk_dec(0, 0, 0, 0, "R4 zero deselect");

    // gate closed keeps stored value
    wr(1, 8'h08);
    wr(0, 8'h7F);
    chk("R2 bit7 only", 32'(ctl_access_en), 0);
    rd(1, 8'h00, "R3 read masked");
    wr(1, 8'h20);
    chk("R3 write dropped", 32'(blk_sel), 32'h08);
    wr(0, 8'h80);
    rd(1, 8'h08, "R3 value kept");

    // R7: program/erase level low
    @(negedge clk); swe = 0;
    @(negedge clk);
    chk_dec(0, 0, 0, 0, "R7 forced clear");
    wr(1, 8'h01);
    chk("R7 write ignored", 32'(blk_sel), 0);
    rd(1, 8'h00, "R7 read zero");
    @(negedge clk); swe = 1;
    @(negedge clk);
    chk("R7 stays zero", 32'(blk_sel), 0);
    wr(1, 8'h02);
    chk_dec(6'h02, 16'h0400, 16'h07FF, 1, "R7 writable again");

    // R1: reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 access after reset", 32'(ctl_access_en), 0);
    chk_dec(0, 0, 0, 0, "R1 after reset");

    repeat (3) @(negedge clk);
    chk("R10 scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule